// File: doc/BRIEF.md
# Branch Direction Counter Table

This block predicts whether a conditional branch is taken. It holds one two-bit saturating counter per entry. The entry is selected by a field of the program counter. A fetch or decode stage gives a PC on the lookup port and gets a taken/not-taken answer back in the same cycle. When the branch resolves later in the pipeline, the execute stage gives the branch's PC and its real outcome on the training port, and the counter for that entry moves one step towards the outcome.

The table has no tags and no valid bits. Two branches whose PCs select the same entry share one counter, and that aliasing is accepted. Entry selection skips PC bits 1 and 0, which are always zero for aligned instructions. The index width is a parameter with a default of 8 bits (256 entries). The block gives a direction only and never a target address.

Top module: `bdp_predictor`

## Requirements
- R1: While reset is asserted and after it is released, every counter holds 1 (weakly not-taken), so a lookup at any PC returns not-taken until that entry is trained.
- R2: `predict_taken_o` is 1 exactly when the counter selected by `lookup_pc_i` holds 2 or 3, which means its upper bit is set.
- R3: A training update with `train_taken_i`=1 raises the addressed counter by one. A counter that already holds 3 stays at 3.
- R4: A training update with `train_taken_i`=0 lowers the addressed counter by one. A counter that already holds 0 stays at 0.
- R5: Both ports select the entry with PC bits [IDX_W+1:2] (bits [9:2] by default). PC bits 1:0 and all bits above IDX_W+1 do not affect which entry is used, so PCs that differ only in those bits share one counter.
- R6: A training request changes nothing unless `train_valid_i` is 1 at the rising clock edge.
- R7: A training update changes only the single addressed counter. Every other entry keeps its value.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the prediction from before the update. The new value shows on the lookup from the next cycle on.
- R9: With default parameters the table has 256 independent entries. Entry 0 (PC 0x000) and entry 255 (PC 0x3FC) are trained and read separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_pc_i | input | PC_W | PC of the branch being predicted |
| predict_taken_o | output | 1 | Combinational prediction, 1 = taken |
| train_valid_i | input | 1 | Training strobe, one update per cycle while high |
| train_pc_i | input | PC_W | PC of the resolved branch |
| train_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The case that is hardest to reach from the ports is a lookup and a training update on the same entry in the same cycle. When both PCs are random, they rarely select the same entry. The counter also has to sit exactly at the 1/2 boundary, because only there does the pre-update value differ from the post-update value. The stimulus forces the collision in a directed case on a freshly reset entry. In the random phase it often copies the training PC into the lookup PC and draws PCs from a small pool of entries with random alias and low bits. The counters then walk through both saturation limits and the collision happens at every counter value.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RST = 2'd1;
  localparam ctr_t CTR_MAX = 2'd3;
  localparam ctr_t CTR_MIN = 2'd0;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_MAX) ? cur : cur + 2'd1;
    else       res = (cur == CTR_MIN) ? cur : cur - 2'd1;
    return res;
  endfunction

  function automatic logic ctr_is_taken(input ctr_t cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/bdp_index.sv
module bdp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int LO = 2;
  localparam int HI = IDX_W + LO - 1;

  // low two bits are always zero for aligned instructions
  assign idx_o = pc_i[HI:LO];

  logic unused_bits;
  generate
    if (PC_W > HI + 1) begin : g_hi
      assign unused_bits = ^{pc_i[PC_W-1:HI+1], pc_i[LO-1:0]};
    end else begin : g_nohi
      assign unused_bits = ^pc_i[LO-1:0];
    end
  endgenerate
endmodule

// File: rtl/bdp_sat_update.sv
module bdp_sat_update
  import bdp_pkg::*;
(
  input  ctr_t cnt_i,
  input  logic taken_i,
  output ctr_t cnt_o
);
  assign cnt_o = ctr_step(cnt_i, taken_i);
endmodule

// File: rtl/bdp_table.sv
module bdp_table
  import bdp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_cnt_o,
  input  logic [IDX_W-1:0] wr_idx_i,
  output ctr_t             wr_old_o,
  input  logic             wr_en_i,
  input  ctr_t             wr_cnt_i
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_t cnt_q [ENTRIES];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      localparam logic [IDX_W-1:0] ME = IDX_W'(g);
      logic hit;
      assign hit = wr_en_i && (wr_idx_i == ME);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  cnt_q[g] <= CTR_RST;
        else if (hit) cnt_q[g] <= wr_cnt_i;
      end

      // R6
      no_strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(cnt_q[g]));

      // R7
      other_entry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_idx_i != ME) |=> $stable(cnt_q[g]));

      // R3, R4
      step_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> ({1'b0, cnt_q[g]} == {1'b0, $past(cnt_q[g])} + 3'd1) ||
                ({1'b0, $past(cnt_q[g])} == {1'b0, cnt_q[g]} + 3'd1) ||
                (cnt_q[g] == $past(cnt_q[g])));
    end
  endgenerate

  // read ports see only registered state: same-cycle updates stay invisible
  assign rd_cnt_o = cnt_q[rd_idx_i];
  assign wr_old_o = cnt_q[wr_idx_i];
endmodule

// File: rtl/bdp_predictor.sv
module bdp_predictor
  import bdp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lookup_pc_i,
  output logic            predict_taken_o,
  input  logic            train_valid_i,
  input  logic [PC_W-1:0] train_pc_i,
  input  logic            train_taken_i
);
  logic [IDX_W-1:0] lk_idx, tr_idx;
  ctr_t lk_cnt, tr_old, tr_new;

  bdp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx (.pc_i(lookup_pc_i), .idx_o(lk_idx));
  bdp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_tr_idx (.pc_i(train_pc_i),  .idx_o(tr_idx));

  bdp_table #(.IDX_W(IDX_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (lk_idx),
    .rd_cnt_o (lk_cnt),
    .wr_idx_i (tr_idx),
    .wr_old_o (tr_old),
    .wr_en_i  (train_valid_i),
    .wr_cnt_i (tr_new)
  );

  bdp_sat_update u_upd (.cnt_i(tr_old), .taken_i(train_taken_i), .cnt_o(tr_new));

  assign predict_taken_o = ctr_is_taken(lk_cnt);

  // R3
  taken_keeps_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_valid_i && train_taken_i && lk_idx == tr_idx && predict_taken_o)
    |=> (!$stable(lookup_pc_i) || predict_taken_o));

  // R4
  not_taken_keeps_nt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_valid_i && !train_taken_i && lk_idx == tr_idx && !predict_taken_o)
    |=> (!$stable(lookup_pc_i) || !predict_taken_o));
endmodule

// File: tb/tb_bdp_predictor.sv
`timescale 1ns/1ps
module tb_bdp_predictor;
  localparam int PC_W = 32;
  localparam int IDX_W = 8;
  localparam int ENT = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [PC_W-1:0] lookup_pc_i = '0;
  logic predict_taken_o;
  logic train_valid_i = 1'b0;
  logic [PC_W-1:0] train_pc_i = '0;
  logic train_taken_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int model [ENT];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bdp_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .lookup_pc_i(lookup_pc_i),
    .predict_taken_o(predict_taken_o), .train_valid_i(train_valid_i),
    .train_pc_i(train_pc_i), .train_taken_i(train_taken_i)
  );

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic int nxt(input int c, input logic t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: predict actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [PC_W-1:0] tpc, input logic tk,
                      input logic [PC_W-1:0] lpc, input string tag);
    @(negedge clk);
    train_valid_i = v; train_pc_i = tpc; train_taken_i = tk; lookup_pc_i = lpc;
    #2;
    check(predict_taken_o, model[idx_of(lpc)] >= 2, tag);
    @(posedge clk);
    if (v) model[idx_of(tpc)] = nxt(model[idx_of(tpc)], tk);
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string tag);
    step(1'b0, 32'h0, 1'b0, pc, tag);
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input logic tk, input string tag);
    step(1'b1, pc, tk, pc ^ 32'h0000_0400, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < ENT; i++) model[i] = 1;
    #1;
    lookup_pc_i = 32'h0000_0100;
    #1;
    check(predict_taken_o, 1'b0, "R1 in reset");
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1: reset value weakly not-taken everywhere
    look(32'h0, "R1");
    look(32'h3FC, "R1");
    for (int i = 0; i < 8; i++) look($urandom, "R1");

    // R2/R3: one taken step crosses to taken; upward saturation
    train(32'h100, 1'b1, "R3");
    look(32'h100, "R2");
    for (int i = 0; i < 4; i++) train(32'h100, 1'b1, "R3");
    train(32'h100, 1'b0, "R3");
    look(32'h100, "R3 saturate high");
    train(32'h100, 1'b0, "R4");
    look(32'h100, "R2");

    // R4: downward saturation
    for (int i = 0; i < 4; i++) train(32'h140, 1'b0, "R4");
    train(32'h140, 1'b1, "R4");
    look(32'h140, "R4 saturate low");
    train(32'h140, 1'b1, "R4");
    look(32'h140, "R4");

    // R5: low bits and high bits ignored
    train(32'h204, 1'b1, "R5");
    train(32'h204, 1'b1, "R5");
    look(32'h206, "R5 low bits");
    look(32'h204 | 32'h0001_0400, "R5 alias");
    look(32'hFFFF_FE07, "R5 alias");

    // R6: no strobe, no change
    for (int i = 0; i < 5; i++) step(1'b0, 32'h180, 1'b1, 32'h0, "R6");
    look(32'h180, "R6");

    // R7: neighbours untouched
    train(32'h014, 1'b1, "R7");
    train(32'h014, 1'b1, "R7");
    look(32'h010, "R7");
    look(32'h018, "R7");
    look(32'h014, "R7");

    // R8: same-cycle collision returns old value, new value next cycle
    step(1'b1, 32'h2A0, 1'b1, 32'h2A0, "R8 pre-update");
    look(32'h2A0, "R8 post-update");

    // R9: first and last entry independent
    train(32'h3FC, 1'b1, "R9");
    train(32'h3FC, 1'b1, "R9");
    look(32'h000, "R9");
    look(32'h3FC, "R9");
    look(32'h400, "R9");

    // random mix: small entry pool, random alias bits, frequent collisions
    for (int i = 0; i < 4000; i++) begin
      logic [PC_W-1:0] tpc, lpc;
      logic v, tk;
      tpc = {$urandom} & 32'hFFFF_F003;
      tpc[IDX_W+1:2] = IDX_W'($urandom_range(0, 5) * 51);
      lpc = ($urandom_range(0, 2) == 0) ? {$urandom} : (tpc ^ ({$urandom} & 32'hFFFF_FC03));
      v = ($urandom_range(0, 3) != 0);
      tk = ($urandom_range(0, 1) == 1);
      step(v, tpc, tk, lpc, "R2 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule